// File: doc/BRIEF.md
# Double-Buffered Converter Code Latch Controller

This block holds the code that drives a digital-to-analog converter in two registers placed one after the other. A host writes a 14-bit word on a parallel bus using active-low chip-select and write strobes. The word lands in a first-stage (staging) register. A separate active-low load strobe decides when the staging value moves into the second-stage (output) register, which drives the converter.

The latch behaviour of a discrete part is emulated with flops on a fast system clock. The three strobes and the data bus pass through matched two-flop synchronisers, so data and strobes stay aligned in time. A register is "transparent" in every clock cycle in which its enable condition holds.

The output register may not follow the staging register while the staging register is open. If load is held low through a write, the new code reaches the output only when the write closes the staging register. A single-cycle pulse marks every change of the output code caused by a transfer. A synchronous clear zeroes both registers.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: The staging register loads the synchronised data bus in every cycle in which chip-select and write are both low. A write window can be closed by raising either strobe.
- R2: While chip-select or write is high, the staging register keeps its contents, whatever the data bus does.
- R3: With load low, raising write (or chip-select) to close the staging register transfers the staged code to `dac_code`. The change appears after the third rising clock edge that follows the strobe change at the pins.
- R4: While the staging register is open, `dac_code` does not change, even with load low.
- R5: While load is high, `dac_code` holds its value regardless of chip-select, write and data.
- R6: When load goes low while the staging register is closed, `dac_code` takes the staged code after the third rising edge. It then follows the staging register for as long as load stays low and the staging register stays closed.
- R7: `xfer_pulse` is high for exactly one cycle, in the same cycle in which `dac_code` takes a transferred value that differs from its previous value. A transfer of an equal value gives no pulse.
- R8: A high `clr` at a rising edge sets both registers to zero after that edge, with `xfer_pulse` low.
- R9: While `rst_n` is low, and after its release, `dac_code` reads zero and `xfer_pulse` reads low until a transfer occurs.
- R10: The staged value is the data bus value present one clock before the closing strobe edge at the pins. Data that changes together with the closing edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous active-high clear of both registers |
| cs_n | input | 1 | Active-low chip-select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| ld_n | input | 1 | Active-low load strobe for the output register (asynchronous) |
| din | input | 14 | Parallel data bus |
| dac_code | output | 14 | Code driving the converter |
| xfer_pulse | output | 1 | One-cycle flag for each change of `dac_code` by a transfer |

## Verification
Assertions check four rules on every cycle. The output code stays stable while the staging register is open or load is high. The staging register stays stable while it is closed. A pulse always comes with a changed code, and clear zeroes everything.

Some behaviour can only be shown by the bench's scenarios, because the strobes pass through synchronisers. These are the exact three-edge latency, which data word is captured when data moves with the closing edge, and the choice between closing by chip-select or by write. The bench compares a behavioural model on every clock and adds directed checks at those boundaries.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

  // Synchronised strobe bundle, all active-low.
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  // Idle (inactive) value of the strobe bundle.
  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};

endpackage

// File: rtl/dbuf_sync_pipe.sv
module dbuf_sync_pipe #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          stage_q[s] <= stage_d;
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbuf_stage_reg.sv
module dbuf_stage_reg #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cs_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              open_o,
  output logic [DATA_W-1:0] code_o
);

  logic              open_w;
  logic              load_en;
  logic [DATA_W-1:0] code_d;
  logic [DATA_W-1:0] code_q;

  // Transparent while both strobes are low.
  assign open_w  = ~cs_n_i & ~wr_n_i;
  assign load_en = clr | open_w;

  always_comb begin
    code_d = code_q;
    if (clr) begin
      code_d = '0;
    end else if (open_w) begin
      code_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (load_en) begin
      code_q <= code_d;
    end
  end

  assign open_o = open_w;
  assign code_o = code_q;

  // R2: a closed staging register keeps its contents
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_w && !clr) |=> $stable(code_q));

endmodule

// File: rtl/dbuf_out_reg.sv
module dbuf_out_reg #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stage_open_i,
  input  logic              ld_n_i,
  input  logic [DATA_W-1:0] stage_code_i,
  output logic [DATA_W-1:0] code_o,
  output logic              xfer_o
);

  logic              pass_en;
  logic [DATA_W-1:0] code_d;
  logic [DATA_W-1:0] code_q;
  logic              xfer_d;
  logic              xfer_q;

  // Transfer only with load low and the staging register closed (inhibit rule).
  assign pass_en = ~ld_n_i & ~stage_open_i;

  always_comb begin
    code_d = code_q;
    xfer_d = 1'b0;
    if (clr) begin
      code_d = '0;
    end else if (pass_en) begin
      code_d = stage_code_i;
      xfer_d = (stage_code_i != code_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= xfer_d;
      if (clr | pass_en) begin
        code_q <= code_d;
      end
    end
  end

  assign code_o = code_q;
  assign xfer_o = xfer_q;

  // R4: no update while the staging register is open
  p_inhibit_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_open_i && !clr) |=> $stable(code_q));

  // R5: load high freezes the output
  p_load_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n_i && !clr) |=> $stable(code_q));

  // R7: a pulse always accompanies a changed code
  p_pulse_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_q |-> (code_q != $past(code_q)));

  // R8: clear zeroes the output with no pulse
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code_q == '0) && !xfer_q);

endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
  import dac_dbuf_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dac_code,
  output logic              xfer_pulse
);

  localparam int RST_STAGES = 2;

  // Reset: asynchronous assertion, synchronous release.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  // Matched synchronisers for strobes and data.
  strobe_t           strobe_raw;
  strobe_t           strobe_s;
  logic [DATA_W-1:0] data_s;

  assign strobe_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ld_n};

  dbuf_sync_pipe #(
    .WIDTH  (STROBE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STROBE_IDLE)
  ) u_strobe_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (strobe_raw),
    .q_o  (strobe_s)
  );

  dbuf_sync_pipe #(
    .WIDTH  (DATA_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_data_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (din),
    .q_o  (data_s)
  );

  logic              stage_open;
  logic [DATA_W-1:0] stage_code;

  dbuf_stage_reg #(.DATA_W(DATA_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (clr),
    .cs_n_i(strobe_s.cs_n),
    .wr_n_i(strobe_s.wr_n),
    .data_i(data_s),
    .open_o(stage_open),
    .code_o(stage_code)
  );

  dbuf_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr         (clr),
    .stage_open_i(stage_open),
    .ld_n_i      (strobe_s.ld_n),
    .stage_code_i(stage_code),
    .code_o      (dac_code),
    .xfer_o      (xfer_pulse)
  );

  // R9: reset state of the outputs
  p_reset_state_r9: assert property (@(posedge clk)
    !rst_int_n |-> (dac_code == '0) && !xfer_pulse);

endmodule

// File: tb/tb_dac_dbuf_ctrl.sv
module tb_dac_dbuf_ctrl;

  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          cs_n, wr_n, ld_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dac_code;
  logic          xfer_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dac_dbuf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .wr_n(wr_n),
    .ld_n(ld_n), .din(din), .dac_code(dac_code), .xfer_pulse(xfer_pulse)
  );

  // ---------------- behavioural reference model ----------------
  // Pin history: each entry {cs_n, wr_n, ld_n, din}; the model acts on
  // the entry two edges old (synchroniser delay).
  logic [DW+2:0] hist[$];
  logic [DW-1:0] m_stage, m_out;
  logic          m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      hist.push_back({3'b111, {DW{1'b0}}});
      hist.push_back({3'b111, {DW{1'b0}}});
      m_stage = '0; m_out = '0; m_pulse = 1'b0;
    end else begin
      logic [DW+2:0] old;
      logic          is_open;
      hist.push_back({cs_n, wr_n, ld_n, din});
      old     = hist.pop_front();
      is_open = (old[DW+2] == 1'b0) && (old[DW+1] == 1'b0);
      m_pulse = 1'b0;
      if (clr) begin
        m_stage = '0;
        m_out   = '0;
      end else begin
        if (!old[DW] && !is_open) begin
          if (m_stage != m_out) m_pulse = 1'b1;
          m_out = m_stage;
        end
        if (is_open) m_stage = old[DW-1:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (dac_code !== m_out || xfer_pulse !== m_pulse) begin
        fails++;
        $display("FAIL R3,R4,R5,R6,R7,R8 model: code=%h pulse=%b expected code=%h pulse=%b",
                 dac_code, xfer_pulse, m_out, m_pulse);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] code_exp,
                     input logic pulse_exp);
    tests++;
    if (dac_code !== code_exp || xfer_pulse !== pulse_exp) begin
      fails++;
      $display("FAIL %s: code=%h pulse=%b expected code=%h pulse=%b",
               req, dac_code, xfer_pulse, code_exp, pulse_exp);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; clr = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
    din = '0;
    step(5);
    chk("R9 in reset", 14'h0000, 1'b0);
    rst_n = 1'b1;
    step(6);
    chk("R9 after reset", 14'h0000, 1'b0);

    // R1 R3 R4 R10: write with load held low
    ld_n = 1'b0;
    step(4);
    chk("R6 transparent zero", 14'h0000, 1'b0);
    cs_n = 1'b0; wr_n = 1'b0; din = 14'h1234;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R4 inhibit while open", 14'h0000, 1'b0);
    end
    din = 14'h0ABC;
    step(3);
    chk("R4 inhibit while open", 14'h0000, 1'b0);
    wr_n = 1'b1; din = 14'h3FFF;  // R10: moves with the closing edge
    step(2);
    chk("R3 not before third edge", 14'h0000, 1'b0);
    step(1);
    chk("R3 R10 transfer on close", 14'h0ABC, 1'b1);
    step(1);
    chk("R7 single-cycle pulse", 14'h0ABC, 1'b0);
    cs_n = 1'b1;
    step(3);

    // R5: load high holds output across a write
    ld_n = 1'b1; step(3);
    cs_n = 1'b0; wr_n = 1'b0; din = 14'h2222;
    step(3);
    wr_n = 1'b1; cs_n = 1'b1;
    step(6);
    chk("R5 load high holds", 14'h0ABC, 1'b0);
    // R6: load falls while closed
    ld_n = 1'b0;
    step(2);
    chk("R6 not before third edge", 14'h0ABC, 1'b0);
    step(1);
    chk("R6 transfer on load", 14'h2222, 1'b1);
    step(2);

    // R2: only one strobe low never opens the staging register
    cs_n = 1'b1; wr_n = 1'b0; din = 14'h1111; step(4);
    cs_n = 1'b0; wr_n = 1'b1; din = 14'h0555; step(4);
    cs_n = 1'b1; wr_n = 1'b1; step(5);
    chk("R2 staging held with one strobe high", 14'h2222, 1'b0);

    // R1: closing by chip-select
    cs_n = 1'b0; wr_n = 1'b0; din = 14'h3001; step(3);
    cs_n = 1'b1;
    step(3);
    chk("R1 close by chip-select", 14'h3001, 1'b1);
    wr_n = 1'b1; step(3);

    // R8: synchronous clear
    clr = 1'b1;
    step(1);
    chk("R8 clear", 14'h0000, 1'b0);
    clr = 1'b0;
    step(4);
    chk("R8 staging also cleared", 14'h0000, 1'b0);

    // R7: rewriting an equal value gives no pulse
    cs_n = 1'b0; wr_n = 1'b0; din = 14'h0000; step(3);
    wr_n = 1'b1; cs_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R7 no pulse on equal value", 14'h0000, 1'b0);
    end

    // mixed patterns, checked by the model every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cs_n = lfsr[0] & lfsr[5];
      wr_n = lfsr[1] & lfsr[7];
      ld_n = lfsr[2] & lfsr[3];
      din  = {lfsr[13:0]};
      clr  = (lfsr[15:11] == 5'h1F);
      step(1 + int'(lfsr[9:8]));
    end
    clr = 1'b0;
    step(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule